// File: doc/BRIEF.md
# Power Mode Transition Controller

This controller follows the operating power mode of a small processor and decides what a sleep instruction leads to. Three modes run code: full-speed, divided-speed and low-speed (slow clock only). When the sleep strobe arrives with the direct-transfer enable set, a valid combination of mode-select bits takes the processor straight from one running mode to another. The move passes through a one-cycle sleep or watch step, and an interrupt pulse then announces that the new mode is in force. The processor never halts during such a move.

Any other request parks the block in sleep or watch with the halted flag raised. A wake interrupt returns it to the mode it left. If the CPU's global interrupt mask was set when a transfer was tried, the parked state ignores wake requests. A move from low-speed to full-speed waits in watch for a settling count of slow-clock ticks, chosen by a 3-bit field, before it completes. The block drives one clock-domain enable that matches the current mode.

Top module: `pmc_top`

## Requirements
- R1: After reset the mode output is full-speed, halted is 0 and dt_irq is 0. Mode codes are: 0 full-speed, 1 divided-speed, 2 low-speed, 3 sleep, 4 watch.
- R2: From full-speed, a sleep strobe with dt_en=1, sby=0, lsel=0, msel=1, dt_ie=1 and imask=0 gives mode 3 for exactly one cycle. The next cycle gives mode 1 with dt_irq high for one cycle, and halted stays 0.
- R3: From divided-speed, a strobe with dt_en=1, sby=0, lsel=0, msel=0, dt_ie=1 and imask=0 gives mode 3 for one cycle, then mode 0 with a dt_irq pulse.
- R4: From full-speed or divided-speed, a strobe with dt_en=1, sby=1, lsel=1, tsrc=1, dt_ie=1 and imask=0 gives mode 4 for one cycle, then mode 2 with a dt_irq pulse.
- R5: From low-speed, a strobe with dt_en=1, sby=1, lsel=0, msel=0, tsrc=1, dt_ie=1 and imask=0 gives mode 4. The block stays in mode 4 until 2^(settle_sel+4) cycles with slow_tick high have passed after entry, and on the next cycle it gives mode 0 with a dt_irq pulse.
- R6: If a valid transfer combination arrives with dt_ie=0, the block parks with halted=1 and raises no dt_irq. One cycle of wake_irq then returns it to the mode it left, with halted 0 and no dt_irq.
- R7: A strobe with dt_en=1 and imask=1 parks the block with halted=1. While parked this way, wake_irq has no effect and the mode does not change.
- R8: Any strobe that is not a valid direct transfer parks the block in sleep (mode 3) when sby=0 and in watch (mode 4) when sby=1.
- R9: Exactly one enable is high at a time. fast_en is high in full-speed, div_en in divided-speed, and slow_en in low-speed and watch. In sleep, the enable of the mode that was left stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| sby | input | 1 | Standby select |
| lsel | input | 1 | Low-speed select |
| msel | input | 1 | Divided-speed select |
| dt_en | input | 1 | Direct-transfer enable |
| tsrc | input | 1 | Timer clock-source bit |
| dt_ie | input | 1 | Direct-transfer interrupt enable |
| imask | input | 1 | CPU global interrupt mask |
| settle_sel | input | 3 | Settling-time select |
| wake_irq | input | 1 | Wake interrupt request |
| slow_tick | input | 1 | One pulse per slow-clock period |
| mode | output | 3 | Current mode code |
| fast_en | output | 1 | Full-speed clock enable |
| div_en | output | 1 | Divided clock enable |
| slow_en | output | 1 | Slow clock enable |
| dt_irq | output | 1 | Direct-transfer interrupt pulse |
| halted | output | 1 | Parked in sleep or watch |

## Verification
A wake request can arrive during a direct transfer: in the single sleep step, or in any cycle of the low-speed to full-speed settling countdown. In that case the wake must not send the block back to its origin. The bench holds wake_irq high through every settling sweep. It checks that watch ends exactly one cycle after the last required slow tick, that the mode is then full-speed and that dt_irq pulses. A slow tick can also fall on the edge that enters watch. That tick must not count, so the bench's expected exit cycle counts only ticks after entry.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [2:0] {
        MD_HIGH  = 3'd0,
        MD_MED   = 3'd1,
        MD_SUB   = 3'd2,
        MD_SLEEP = 3'd3,
        MD_WATCH = 3'd4
    } pmode_e;

    typedef struct packed {
        pmode_e mode;
        pmode_e orig;
        pmode_e tgt;
        logic   direct;
        logic   lock;
        logic   irq;
    } pmc_state_t;

endpackage

// File: rtl/pmc_route.sv
module pmc_route
    import pmc_pkg::*;
(
    input  pmode_e cur,
    input  logic   sby,
    input  logic   lsel,
    input  logic   msel,
    input  logic   dt_en,
    input  logic   tsrc,
    output logic   hit,
    output pmode_e tgt,
    output logic   via_watch
);
    always_comb begin
        hit       = 1'b0;
        tgt       = cur;
        via_watch = 1'b0;
        if (dt_en) begin
            case (cur)
                MD_HIGH: begin
                    if (!sby && !lsel && msel) begin
                        hit = 1'b1;
                        tgt = MD_MED;
                    end else if (sby && lsel && tsrc) begin
                        hit       = 1'b1;
                        tgt       = MD_SUB;
                        via_watch = 1'b1;
                    end
                end
                MD_MED: begin
                    if (!sby && !lsel && !msel) begin
                        hit = 1'b1;
                        tgt = MD_HIGH;
                    end else if (sby && lsel && tsrc) begin
                        hit       = 1'b1;
                        tgt       = MD_SUB;
                        via_watch = 1'b1;
                    end
                end
                MD_SUB: begin
                    if (sby && !lsel && !msel && tsrc) begin
                        hit       = 1'b1;
                        tgt       = MD_HIGH;
                        via_watch = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
    parameter int SEL_W = 3,
    parameter int BASE  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick,
    output logic             zero
);
    localparam int MAX_EXP = (1 << SEL_W) - 1 + BASE;
    localparam int CNT_W   = MAX_EXP + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = CNT_W'(1) << (int'(sel) + BASE);
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    // R5: the countdown never exceeds the largest settling length
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (CNT_W'(1) << MAX_EXP));

    // R5: without load, count moves by at most one per tick
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int SETTLE_BASE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_req,
    input  logic             sby,
    input  logic             lsel,
    input  logic             msel,
    input  logic             dt_en,
    input  logic             tsrc,
    input  logic             dt_ie,
    input  logic             imask,
    input  logic [SEL_W-1:0] settle_sel,
    input  logic             wake_irq,
    input  logic             slow_tick,
    output logic [2:0]       mode,
    output logic             fast_en,
    output logic             div_en,
    output logic             slow_en,
    output logic             dt_irq,
    output logic             halted
);
    pmc_state_t s_d, s_q;
    logic   rt_hit, rt_watch, st_load, st_zero;
    pmode_e rt_tgt;

    pmc_route u_route (
        .cur(s_q.mode), .sby(sby), .lsel(lsel), .msel(msel),
        .dt_en(dt_en), .tsrc(tsrc),
        .hit(rt_hit), .tgt(rt_tgt), .via_watch(rt_watch)
    );

    pmc_settle #(.SEL_W(SEL_W), .BASE(SETTLE_BASE)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(st_load), .sel(settle_sel),
        .tick(slow_tick), .zero(st_zero)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;
        st_load = 1'b0;
        case (s_q.mode)
            MD_HIGH, MD_MED, MD_SUB: begin
                if (sleep_req) begin
                    s_d.orig = s_q.mode;
                    if (rt_hit && dt_ie && !imask) begin
                        s_d.mode   = rt_watch ? MD_WATCH : MD_SLEEP;
                        s_d.tgt    = rt_tgt;
                        s_d.direct = 1'b1;
                        s_d.lock   = 1'b0;
                        st_load    = rt_watch && (s_q.mode == MD_SUB);
                    end else begin
                        s_d.mode   = sby ? MD_WATCH : MD_SLEEP;
                        s_d.tgt    = s_q.mode;
                        s_d.direct = 1'b0;
                        s_d.lock   = imask && dt_en;
                    end
                end
            end
            default: begin
                if (s_q.direct) begin
                    if (s_q.mode == MD_SLEEP || s_q.orig != MD_SUB || st_zero) begin
                        s_d.mode   = s_q.tgt;
                        s_d.direct = 1'b0;
                        s_d.irq    = 1'b1;
                    end
                end else if (wake_irq && !s_q.lock) begin
                    s_d.mode = s_q.orig;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '{mode: MD_HIGH, orig: MD_HIGH, tgt: MD_HIGH,
                     direct: 1'b0, lock: 1'b0, irq: 1'b0};
        else
            s_q <= s_d;
    end

    logic in_sleep;
    assign in_sleep = (s_q.mode == MD_SLEEP);
    assign mode     = s_q.mode;
    assign dt_irq   = s_q.irq;
    assign halted   = (in_sleep || s_q.mode == MD_WATCH) && !s_q.direct;
    assign fast_en  = (s_q.mode == MD_HIGH) || (in_sleep && s_q.orig == MD_HIGH);
    assign div_en   = (s_q.mode == MD_MED)  || (in_sleep && s_q.orig == MD_MED);
    assign slow_en  = (s_q.mode == MD_SUB)  || (s_q.mode == MD_WATCH) ||
                      (in_sleep && s_q.orig == MD_SUB);

    // R2: a direct sleep step lasts one cycle and ends with the pulse
    assert_sleep_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && s_q.direct) |=> (dt_irq && !halted));

    // R2: the transfer pulse appears only in a running mode
    assert_irq_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dt_irq |-> (!halted && (mode == 3'd0 || mode == 3'd1 || mode == 3'd2)));

    // R6: an unmasked wake returns to the origin without a pulse
    assert_wake_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !s_q.lock && wake_irq) |=> (mode == 3'($past(s_q.orig)) && !dt_irq));

    // R7: a masked park is never left
    assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && s_q.lock) |=> (halted && $stable(mode)));

    // R9: one clock enable at a time
    assert_enable_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({fast_en, div_en, slow_en}) == 1);
endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 0, sby = 0, lsel = 0, msel = 0, dt_en = 0, tsrc = 0;
    logic       dt_ie = 0, imask = 0, wake_irq = 0, slow_tick = 1;
    logic [2:0] settle_sel = 3'd0;
    logic [2:0] mode;
    logic       fast_en, div_en, slow_en, dt_irq, halted;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pmc_top dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .sby(sby), .lsel(lsel),
        .msel(msel), .dt_en(dt_en), .tsrc(tsrc), .dt_ie(dt_ie), .imask(imask),
        .settle_sel(settle_sel), .wake_irq(wake_irq), .slow_tick(slow_tick),
        .mode(mode), .fast_en(fast_en), .div_en(div_en), .slow_en(slow_en),
        .dt_irq(dt_irq), .halted(halted)
    );

    localparam int HI = 0, MD = 1, SB = 2, SL = 3, WA = 4;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_req = 0; wake_irq = 0; slow_tick = 1;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic set_bits(input logic s, input logic l, input logic m,
                            input logic d, input logic t, input logic ie, input logic im);
        sby = s; lsel = l; msel = m; dt_en = d; tsrc = t; dt_ie = ie; imask = im;
    endtask

    task automatic strobe();
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
    endtask

    // enable pattern expected for a mode and origin, packed {fast,div,slow}
    function automatic int enables(input int m, input int org);
        int eff;
        eff = (m == SL) ? org : m;
        if (eff == HI) return 4;
        if (eff == MD) return 2;
        return 1;
    endfunction

    task automatic go_mode(input int m);
        if (m == MD) begin
            set_bits(0, 0, 1, 1, 0, 1, 0); strobe(); step(); step();
        end else if (m == SB) begin
            set_bits(1, 1, 0, 1, 1, 1, 0); strobe(); step(); step();
        end
    endtask

    // expected route: returns target or -1 when no direct transfer
    function automatic int route(input int org, input int s, input int l, input int m,
                                 input int d, input int t);
        if (d == 0) return -1;
        if (org == HI && s == 0 && l == 0 && m == 1) return MD;
        if (org == MD && s == 0 && l == 0 && m == 0) return HI;
        if ((org == HI || org == MD) && s == 1 && l == 1 && t == 1) return SB;
        if (org == SB && s == 1 && l == 0 && m == 0 && t == 1) return HI;
        return -1;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: reset state
        chk("R1 mode", int'(mode), HI);
        chk("R1 halted", int'(halted), 0);
        chk("R1 dt_irq", int'(dt_irq), 0);
        chk("R9 reset enables", int'({fast_en, div_en, slow_en}), 4);

        // sweep: origin x five control bits x (dt_ie, imask)
        for (int org = 0; org < 3; org++) begin
            for (int bits = 0; bits < 32; bits++) begin
                for (int gi = 0; gi < 4; gi++) begin
                    int s, l, m, d, t, ie, im, tg, wcyc;
                    string rq;
                    s = (bits >> 4) & 1; l = (bits >> 3) & 1; m = (bits >> 2) & 1;
                    d = (bits >> 1) & 1; t = bits & 1; ie = gi & 1; im = (gi >> 1) & 1;
                    tg = route(org, s, l, m, d, t);
                    do_reset();
                    settle_sel = 3'd0;
                    go_mode(org);
                    chk("R2 reach origin", int'(mode), org);
                    set_bits(s[0], l[0], m[0], d[0], t[0], ie[0], im[0]);
                    strobe();
                    if (tg >= 0 && ie == 1 && im == 0) begin
                        rq = (tg == MD) ? "R2" : (tg == SB) ? "R4" : (org == MD) ? "R3" : "R5";
                        chk({rq, " step mode"}, int'(mode), (tg == SB || org == SB) ? WA : SL);
                        chk({rq, " no halt"}, int'(halted), 0);
                        wcyc = 0;
                        while ((mode == 3'(SL) || mode == 3'(WA)) && wcyc < 40) begin
                            wcyc++;
                            step();
                        end
                        // R5 with select 0 and tick every cycle: 16 + 1 cycles in watch
                        chk({rq, " step length"}, wcyc, (org == SB) ? 17 : 1);
                        chk({rq, " target"}, int'(mode), tg);
                        chk({rq, " irq"}, int'(dt_irq), 1);
                        chk("R9 enables", int'({fast_en, div_en, slow_en}), enables(tg, tg));
                        step();
                        chk({rq, " irq one cycle"}, int'(dt_irq), 0);
                    end else begin
                        rq = (tg >= 0 && ie == 0 && im == 0) ? "R6" :
                             (d == 1 && im == 1) ? "R7" : "R8";
                        chk({rq, " park mode"}, int'(mode), s ? WA : SL);
                        chk({rq, " halted"}, int'(halted), 1);
                        chk({rq, " no irq"}, int'(dt_irq), 0);
                        chk("R9 park enables", int'({fast_en, div_en, slow_en}),
                            enables(s ? WA : SL, org));
                        wake_irq = 1'b1;
                        step();
                        wake_irq = 1'b0;
                        if (d == 1 && im == 1) begin
                            chk("R7 wake ignored", int'(mode), s ? WA : SL);
                            chk("R7 still halted", int'(halted), 1);
                        end else begin
                            chk({rq, " wake return"}, int'(mode), org);
                            chk({rq, " wake unhalt"}, int'(halted), 0);
                            chk({rq, " wake no irq"}, int'(dt_irq), 0);
                        end
                    end
                end
            end
        end

        // R5: settling length for every select, sparse ticks, wake held high
        for (int sel = 0; sel < 8; sel++) begin
            int need, got, k, cyc;
            logic left;
            do_reset();
            go_mode(SB);
            settle_sel = 3'(sel);
            need = 1 << (sel + 4);
            set_bits(1, 0, 0, 1, 1, 1, 0);
            slow_tick = 1'b1;
            wake_irq = 1'b1;
            strobe();
            chk("R5 enter watch", int'(mode), WA);
            got = 0; k = 0; cyc = 0; left = 1'b0;
            while (!left && cyc < 9000) begin
                int prev;
                logic tv;
                prev = got;
                tv = ((k % 3) == 0);
                slow_tick = tv;
                k++; cyc++;
                step();
                if (prev == need) begin
                    chk("R5 exit on time", int'(mode), HI);
                    chk("R5 irq at exit", int'(dt_irq), 1);
                    left = 1'b1;
                end else if (mode != 3'(WA)) begin
                    chk("R5 early exit", int'(mode), WA);
                    left = 1'b1;
                end else begin
                    got = prev + int'(tv);
                end
            end
            wake_irq = 1'b0;
            slow_tick = 1'b1;
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule